// File: doc/BRIEF.md
# SCSI Controller Register and Bus-Drive Interface

This block is the register file that a CPU uses to control a small SCSI bus controller. It decodes byte writes to eight addresses into drive requests for the SCSI control and data lines. Each request is an active-high signal held in flops, and an open-collector stage outside the block turns it into the real line. Reads return a packed view of the live bus lines, together with flags supplied by the neighbouring arbitration and DMA blocks.

A mode bit sets the controller's role. In target role it drives the four phase lines from the target command register. In initiator role it drives only the acknowledge and attention lines, which come from the initiator command register. A test flag in the initiator command stops all driving, but the stored values stay as they were. An interrupt flag is set by a pulse from a neighbouring block, and the CPU clears it by reading address 7.

Top module: `scsi_regif`

## Requirements
- R1: After reset, every drive output and irq_o are 0. Reads of addresses 1, 2 and 3 return 0 when the arbitration flags are low.
- R2: The initiator command register is at address 1. Its bit 7 drives RST, bit 3 drives BSY and bit 2 drives SEL, in both roles. Each takes effect at the clock edge that captures the write.
- R3: When mode register (address 2) bit 6 is 0 (initiator role), ACK follows initiator command bit 4 and ATN follows bit 1. REQ, MSG, C/D and I/O are not driven.
- R4: When mode bit 6 is 1 (target role), the target command register (address 3) drives REQ from bit 3, MSG from bit 2, C/D from bit 1 and I/O from bit 0. ACK and ATN are not driven.
- R5: The byte written to address 0 appears on drv_data, with drv_data_en high, only while initiator command bit 0 is 1. Otherwise drv_data_en is 0 and drv_data is 0.
- R6: While initiator command bit 6 is 1, no drive output is asserted. Every register keeps its value, and the values apply again once the bit is cleared.
- R7: A read of address 4 returns {RST, BSY, REQ, MSG, C/D, I/O, SEL, DBP} of the live bus, bit 7 first. A read of address 0 returns the live data bus.
- R8: A read of address 1 returns the stored initiator command, except that bit 6 is arb_busy_i and bit 5 is arb_lost_i. Address 2 reads back the mode. Address 3 reads back the target command in bits 3:0, with zeros above.
- R9: A read of address 5 returns the following fields. Bits 5 and 2 are zero.
  - bit 7: dma_end_i
  - bit 6: dma_req_i
  - bit 4: the interrupt flag
  - bit 3: phase match, meaning target command bits 2:0 equal the live {MSG, C/D, I/O}
  - bit 1: live ATN
  - bit 0: live ACK
- R10: irq_set_i sets irq_o at the next edge. A read of address 7 clears it, and a set in the same cycle wins over the clear. Reads of addresses 6 and 7 return 0xFF.
- R11: Writes to addresses 4 to 7 change no register and no drive output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Access strobe, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational on addr |
| bus_data_i | input | 8 | Live data lines |
| bus_rst_i | input | 1 | Live RST |
| bus_bsy_i | input | 1 | Live BSY |
| bus_req_i | input | 1 | Live REQ |
| bus_msg_i | input | 1 | Live MSG |
| bus_cd_i | input | 1 | Live C/D |
| bus_io_i | input | 1 | Live I/O |
| bus_sel_i | input | 1 | Live SEL |
| bus_dbp_i | input | 1 | Live data parity |
| bus_atn_i | input | 1 | Live ATN |
| bus_ack_i | input | 1 | Live ACK |
| arb_busy_i | input | 1 | Arbitration in progress flag |
| arb_lost_i | input | 1 | Lost arbitration flag |
| dma_end_i | input | 1 | End of DMA flag |
| dma_req_i | input | 1 | DMA request flag |
| irq_set_i | input | 1 | Interrupt set pulse |
| irq_o | output | 1 | Interrupt flag |
| drv_rst | output | 1 | Drive RST |
| drv_bsy | output | 1 | Drive BSY |
| drv_sel | output | 1 | Drive SEL |
| drv_ack | output | 1 | Drive ACK |
| drv_atn | output | 1 | Drive ATN |
| drv_req | output | 1 | Drive REQ |
| drv_msg | output | 1 | Drive MSG |
| drv_cd | output | 1 | Drive C/D |
| drv_io | output | 1 | Drive I/O |
| drv_data_en | output | 1 | Enable data line drive |
| drv_data | output | 8 | Data to drive |

## Verification
The assertions assume that cs, wr, addr, wdata and irq_set_i change only away from the rising edge. They also assume that an access lasts exactly one cycle, so that one write is captured once. The bench drives all inputs on the falling edge and holds cs high for a single cycle. It varies the live bus inputs and the neighbouring flags freely between accesses, because the block only samples them combinationally.

// File: rtl/scsi_regif.sv
module scsi_regif (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       wr,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] bus_data_i,
  input  logic       bus_rst_i,
  input  logic       bus_bsy_i,
  input  logic       bus_req_i,
  input  logic       bus_msg_i,
  input  logic       bus_cd_i,
  input  logic       bus_io_i,
  input  logic       bus_sel_i,
  input  logic       bus_dbp_i,
  input  logic       bus_atn_i,
  input  logic       bus_ack_i,
  input  logic       arb_busy_i,
  input  logic       arb_lost_i,
  input  logic       dma_end_i,
  input  logic       dma_req_i,
  input  logic       irq_set_i,
  output logic       irq_o,
  output logic       drv_rst,
  output logic       drv_bsy,
  output logic       drv_sel,
  output logic       drv_ack,
  output logic       drv_atn,
  output logic       drv_req,
  output logic       drv_msg,
  output logic       drv_cd,
  output logic       drv_io,
  output logic       drv_data_en,
  output logic [7:0] drv_data
);

  logic [7:0] out_byte;
  logic [7:0] mode_q;
  logic [3:0] phase_q;
  logic       cmd_rst, cmd_bsy, cmd_sel, cmd_ack, cmd_atn, cmd_den, test_q;
  logic       irq_q;

  wire wr_hit = cs && wr;
  wire rd_clr = cs && !wr && (addr == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_byte <= '0;
      mode_q   <= '0;
      phase_q  <= '0;
      {cmd_rst, test_q, cmd_ack, cmd_bsy, cmd_sel, cmd_atn, cmd_den} <= '0;
    end else if (wr_hit) begin
      case (addr)
        3'd0: out_byte <= wdata;
        3'd1: {cmd_rst, test_q, cmd_ack, cmd_bsy, cmd_sel, cmd_atn, cmd_den}
                <= {wdata[7:6], wdata[4:0]};
        3'd2: mode_q  <= wdata;
        3'd3: phase_q <= wdata[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (irq_set_i) irq_q <= 1'b1;
    else if (rd_clr)    irq_q <= 1'b0;
  end

  wire live   = !test_q;
  wire target = mode_q[6];

  assign irq_o       = irq_q;
  assign drv_rst     = live & cmd_rst;
  assign drv_bsy     = live & cmd_bsy;
  assign drv_sel     = live & cmd_sel;
  assign drv_ack     = live & !target & cmd_ack;
  assign drv_atn     = live & !target & cmd_atn;
  assign drv_req     = live & target & phase_q[3];
  assign drv_msg     = live & target & phase_q[2];
  assign drv_cd      = live & target & phase_q[1];
  assign drv_io      = live & target & phase_q[0];
  assign drv_data_en = live & cmd_den;
  assign drv_data    = drv_data_en ? out_byte : 8'h00;

  wire phase_ok = (phase_q[2:0] == {bus_msg_i, bus_cd_i, bus_io_i});

  always_comb begin
    case (addr)
      3'd0: rdata = bus_data_i;
      3'd1: rdata = {cmd_rst, arb_busy_i, arb_lost_i, cmd_ack, cmd_bsy, cmd_sel, cmd_atn, cmd_den};
      3'd2: rdata = mode_q;
      3'd3: rdata = {4'h0, phase_q};
      3'd4: rdata = {bus_rst_i, bus_bsy_i, bus_req_i, bus_msg_i,
                     bus_cd_i, bus_io_i, bus_sel_i, bus_dbp_i};
      3'd5: rdata = {dma_end_i, dma_req_i, 1'b0, irq_q, phase_ok, 1'b0, bus_atn_i, bus_ack_i};
      default: rdata = 8'hFF;
    endcase
  end

  wire [10:0] drv_vec = {drv_rst, drv_bsy, drv_sel, drv_ack, drv_atn, drv_req,
                         drv_msg, drv_cd, drv_io, drv_data_en, |drv_data};

  p_test_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && addr == 3'd1 && wdata[6]) |=> (drv_vec == 11'd0));

  p_target_no_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && addr == 3'd2 && wdata[6]) |=> (!drv_ack && !drv_atn));

  p_data_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && addr == 3'd1 && !wdata[0]) |=> (!drv_data_en && drv_data == 8'h00));

  p_high_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && addr[2] && !irq_set_i) |=> ($stable(drv_vec) && $stable(drv_data) && $stable(irq_o)));

  p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_i |=> irq_o);

  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !irq_set_i) |=> !irq_o);

endmodule

// File: tb/scsi_regif_bench.sv
module scsi_regif_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic cs = 0, wr = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata, bus_data_i = 0, drv_data;
  logic bus_rst_i = 0, bus_bsy_i = 0, bus_req_i = 0, bus_msg_i = 0, bus_cd_i = 0;
  logic bus_io_i = 0, bus_sel_i = 0, bus_dbp_i = 0, bus_atn_i = 0, bus_ack_i = 0;
  logic arb_busy_i = 0, arb_lost_i = 0, dma_end_i = 0, dma_req_i = 0, irq_set_i = 0;
  logic irq_o, drv_rst, drv_bsy, drv_sel, drv_ack, drv_atn, drv_req, drv_msg, drv_cd, drv_io, drv_data_en;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_odr = 0, m_icr = 0, m_mode = 0;
  logic [3:0] m_tcr = 0;
  logic m_irq = 0;

  always #5 clk = ~clk;

  scsi_regif u_scsi_regif (.*);

  function automatic logic [18:0] exp_drv();
    logic q, t, den;
    q = m_icr[6]; t = m_mode[6]; den = !q & m_icr[0];
    return {!q & m_icr[7], !q & m_icr[3], !q & m_icr[2],
            !q & !t & m_icr[4], !q & !t & m_icr[1],
            !q & t & m_tcr[3], !q & t & m_tcr[2], !q & t & m_tcr[1], !q & t & m_tcr[0],
            den, den ? m_odr : 8'h00};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return bus_data_i;
      3'd1: return {m_icr[7], arb_busy_i, arb_lost_i, m_icr[4:0]};
      3'd2: return m_mode;
      3'd3: return {4'h0, m_tcr};
      3'd4: return {bus_rst_i, bus_bsy_i, bus_req_i, bus_msg_i, bus_cd_i, bus_io_i, bus_sel_i, bus_dbp_i};
      3'd5: return {dma_end_i, dma_req_i, 1'b0, m_irq,
                    m_tcr[2:0] == {bus_msg_i, bus_cd_i, bus_io_i}, 1'b0, bus_atn_i, bus_ack_i};
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_drv(input string tag);
    check(tag, {drv_rst, drv_bsy, drv_sel, drv_ack, drv_atn, drv_req, drv_msg, drv_cd, drv_io,
                drv_data_en, drv_data}, exp_drv());
    check({tag, " irq"}, irq_o, m_irq);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
    case (a)
      3'd0: m_odr = d;
      3'd1: m_icr = {d[7:6], 1'b0, d[4:0]};
      3'd2: m_mode = d;
      3'd3: m_tcr = d[3:0];
      default: ;
    endcase
  endtask

  task automatic do_read(input logic [2:0] a, input string tag);
    @(negedge clk); cs = 1; wr = 0; addr = a;
    #1 check(tag, rdata, exp_rd(a));
    @(negedge clk); cs = 0;
    if (a == 3'd7 && !irq_set_i) m_irq = 0;
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq_set_i = 1;
    @(negedge clk); irq_set_i = 0; m_irq = 1;
  endtask

  task automatic rand_bus();
    {bus_rst_i, bus_bsy_i, bus_req_i, bus_msg_i, bus_cd_i, bus_io_i, bus_sel_i, bus_dbp_i} = 8'($urandom);
    {bus_atn_i, bus_ack_i, arb_busy_i, arb_lost_i, dma_end_i, dma_req_i} = 6'($urandom);
    bus_data_i = 8'($urandom);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5C51));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_drv("R1 reset drives");
    do_read(3'd1, "R1 reset icr");
    do_read(3'd2, "R1 reset mode");
    do_read(3'd3, "R1 reset tcr");

    do_write(3'd1, 8'h8C); check_drv("R2 rst bsy sel");
    do_write(3'd1, 8'h12); check_drv("R3 initiator ack atn");
    do_write(3'd3, 8'h0F); check_drv("R3 target lines idle");
    do_write(3'd2, 8'h40); check_drv("R4 target phase");
    do_write(3'd3, 8'h0A); check_drv("R4 phase 1010");
    do_write(3'd0, 8'hA5); check_drv("R5 data released");
    do_write(3'd1, 8'h01); check_drv("R5 data driven");
    do_write(3'd1, 8'hDF); check_drv("R6 test quiet");
    do_read(3'd1, "R6 icr retained");
    do_read(3'd3, "R6 tcr retained");
    do_write(3'd1, 8'h9F); check_drv("R6 drives back");

    bus_rst_i = 1; bus_req_i = 1; bus_cd_i = 1; bus_dbp_i = 1;
    do_read(3'd4, "R7 bus snapshot");
    bus_data_i = 8'h3C; do_read(3'd0, "R7 data bus");
    arb_busy_i = 1; do_read(3'd1, "R8 arb busy");
    arb_busy_i = 0; arb_lost_i = 1; do_read(3'd1, "R8 arb lost");
    do_read(3'd2, "R8 mode readback");
    m_tcr = m_tcr; do_write(3'd3, 8'hF2);
    bus_msg_i = 0; bus_cd_i = 1; bus_io_i = 0;
    do_read(3'd3, "R8 tcr upper zero");
    do_read(3'd5, "R9 phase match");
    bus_io_i = 1; dma_end_i = 1; bus_ack_i = 1;
    do_read(3'd5, "R9 phase mismatch");

    pulse_irq(); check_drv("R10 irq set");
    do_read(3'd5, "R9 irq bit");
    do_read(3'd6, "R10 addr6 ff");
    check_drv("R10 addr6 keeps irq");
    do_read(3'd7, "R10 addr7 ff");
    check_drv("R10 irq cleared");
    pulse_irq();
    @(negedge clk); irq_set_i = 1; cs = 1; wr = 0; addr = 3'd7;
    @(negedge clk); irq_set_i = 0; cs = 0; m_irq = 1;
    check_drv("R10 set beats clear");

    for (int a = 4; a < 8; a++) begin
      do_write(3'(a), 8'hFF); check_drv("R11 high write ignored");
    end
    do_read(3'd1, "R11 icr unchanged");
    do_read(3'd2, "R11 mode unchanged");

    for (int i = 0; i < 400; i++) begin
      int op;
      rand_bus();
      op = $urandom_range(0, 9);
      if (op < 5) begin
        do_write(3'($urandom), 8'($urandom)); check_drv("R2 R3 R4 R5 R6 R11 random drive");
      end else if (op < 9) begin
        do_read(3'($urandom), "R7 R8 R9 R10 random read");
      end else begin
        pulse_irq(); check_drv("R10 random irq");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule